// File: doc/BRIEF.md
# SD Host Block-Write Command Sequencer

This block drives a complete block write to an SD or MMC card from the host side. A one-cycle start pulse supplies the card's relative address, a block count, a 32-bit block address and a bus-width select. The sequencer then runs the command ordering by itself. It polls the card until it reports ready for data. It fixes the block length to 512 bytes and, for the 4-bit bus, switches the card's bus width with an application-command pair. It then opens either a single-block or a multi-block write.

Commands leave through a request/done handshake towards a separate command-line serializer: opcode, argument, control word and a fixed auxiliary byte are held until the serializer pulses response-done. Payload words are pulled from a source port and written into the transmit FIFO in bursts. Each burst waits for the FIFO's grant flag. The burst size follows the bus width, so that every 512-byte block takes a whole number of bursts. Once the data-line engine reports completion and an idle bus, a stop command closes multi-block writes.

Top module: `sd_blkwr_seq`

## Requirements
- R1: After reset, busy, done, err, cmd_req, fifo_wr and src_rd are all low.
- R2: After start, the block issues opcode 13 with argument {rca, 16'h0000} and control 0x01. It re-issues that command until the captured response status has bit 8 (ready for data) set.
- R3: After the ready status, the block issues opcode 16 with argument 0x200 and control 0x01.
- R4: With wide=1, opcode 55 (argument {rca, 16'h0000}, control 0x01) and then opcode 6 (argument 0x2, control 0x01) follow. With wide=0 neither command is issued.
- R5: The write command is opcode 24 when blk_count is 1 and opcode 25 otherwise. Its argument is blk_addr and its control is 0x19.
- R6: Every command carries cmd_aux = 0x40. cmd_req stays high with opcode, argument and control unchanged until the cycle in which cmd_done is high.
- R7: No word is written to the FIFO until fifo_empty has been seen high after the write command completed.
- R8: Words are written in bursts: 32 words (8 bursts per block) with wide=1, and 8 words (32 bursts per block) with wide=0. Every burst starts only after fifo_burst_rdy is seen high. Words are forwarded in source order, each one after a src_rd strobe, for a total of 256 words per block.
- R9: After the last burst the block waits for op_done and then for bus_stopped. Only then, and only when blk_count is greater than 1, it issues opcode 12 with argument 0 and control 0x41.
- R10: On completion busy falls and done rises. done stays high until the next accepted start.
- R11: If rsp_timeout or rsp_crc_err is high together with cmd_done, the sequence aborts. err rises, busy falls and no further command is issued. err stays high until the next accepted start, which clears it.
- R12: A start pulse while busy is ignored: the running sequence, its parameters and its data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| rca | input | 16 | Card relative address |
| blk_count | input | CNT_W | Number of 512-byte blocks, 1 or more |
| blk_addr | input | 32 | Card block address |
| wide | input | 1 | 1 selects the 4-bit data bus, 0 the 1-bit bus |
| busy | output | 1 | Sequence running |
| done | output | 1 | Last sequence finished without error |
| err | output | 1 | Last sequence aborted on a response error |
| cmd_req | output | 1 | Command request, held until cmd_done |
| cmd_opcode | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_ctrl | output | 8 | Command control word |
| cmd_aux | output | 8 | Auxiliary command byte, always 0x40 |
| cmd_done | input | 1 | Response received for the pending command |
| rsp_status | input | STAT_W | Response status word, valid with cmd_done |
| rsp_timeout | input | 1 | Response timeout, valid with cmd_done |
| rsp_crc_err | input | 1 | Response CRC error, valid with cmd_done |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| fifo_burst_rdy | input | 1 | FIFO grants room for the next burst |
| op_done | input | 1 | Data-line engine finished the transfer |
| bus_stopped | input | 1 | Card data bus has gone idle |
| src_rd | output | 1 | Source read strobe, one word per cycle |
| src_data | input | DATA_W | Source word, valid in the cycle of src_rd |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | FIFO write data |

## Verification
The assertions take for granted that the serializer pulses cmd_done only while a request is pending, and that the error flags only qualify that pulse. They also assume blk_count is never zero and that src_data is valid in the same cycle as src_rd. The bench's responder model raises cmd_done a fixed number of cycles after it sees a new request and drives the error flags only in that cycle. Its source model advances its counter on each strobe, and every run uses block counts between 1 and 3, so the stimulus stays within those assumptions. The FIFO model withdraws its burst grant after each full burst, and the bench raises op_done and bus_stopped only some cycles after the final word, so any early step by the design becomes visible at the ports.

// File: rtl/sd_blkwr_pkg.sv
package sd_blkwr_pkg;
  localparam int OP_W   = 6;
  localparam int ARG_W  = 32;
  localparam int CTRL_W = 8;
  localparam int RCA_W  = 16;

  localparam logic [OP_W-1:0] OP_STATUS   = 6'd13;
  localparam logic [OP_W-1:0] OP_BLEN     = 6'd16;
  localparam logic [OP_W-1:0] OP_APP      = 6'd55;
  localparam logic [OP_W-1:0] OP_BUSW     = 6'd6;
  localparam logic [OP_W-1:0] OP_WR_ONE   = 6'd24;
  localparam logic [OP_W-1:0] OP_WR_MANY  = 6'd25;
  localparam logic [OP_W-1:0] OP_STOP     = 6'd12;

  localparam logic [CTRL_W-1:0] CTL_RESP  = 8'h01;
  localparam logic [CTRL_W-1:0] CTL_DATA  = 8'h19;
  localparam logic [CTRL_W-1:0] CTL_STOP  = 8'h41;
  localparam logic [CTRL_W-1:0] CTL_AUX   = 8'h40;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WAIT_EMPTY, S_WAIT_RDY, S_BURST, S_WAIT_OP, S_WAIT_BUS
  } state_t;

  typedef enum logic [2:0] {
    STP_STATUS, STP_BLEN, STP_APP, STP_BUSW, STP_WRITE, STP_STOP
  } step_t;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ARG_W-1:0]  arg;
    logic [CTRL_W-1:0] ctrl;
  } cmd_t;

  function automatic cmd_t cmd_of(step_t s, logic [RCA_W-1:0] rca,
                                  logic [ARG_W-1:0] addr, logic multi);
    cmd_t c;
    c.ctrl = CTL_RESP;
    case (s)
      STP_STATUS: begin c.op = OP_STATUS; c.arg = {rca, 16'h0000}; end
      STP_BLEN:   begin c.op = OP_BLEN;   c.arg = 32'h0000_0200;   end
      STP_APP:    begin c.op = OP_APP;    c.arg = {rca, 16'h0000}; end
      STP_BUSW:   begin c.op = OP_BUSW;   c.arg = 32'h0000_0002;   end
      STP_WRITE:  begin
        c.op   = multi ? OP_WR_MANY : OP_WR_ONE;
        c.arg  = addr;
        c.ctrl = CTL_DATA;
      end
      default:    begin c.op = OP_STOP; c.arg = '0; c.ctrl = CTL_STOP; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
  import sd_blkwr_pkg::*;
#(
  parameter int STAT_W  = 32,
  parameter int RDY_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  cmd_t              cmd_in,
  output logic              cmd_req,
  output logic [OP_W-1:0]   cmd_opcode,
  output logic [ARG_W-1:0]  cmd_arg,
  output logic [CTRL_W-1:0] cmd_ctrl,
  output logic [CTRL_W-1:0] cmd_aux,
  input  logic              cmd_done,
  input  logic [STAT_W-1:0] rsp_status,
  input  logic              rsp_timeout,
  input  logic              rsp_crc_err,
  output logic              ok,
  output logic              fail,
  output logic [STAT_W-1:0] stat_q,
  output logic              card_rdy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_req    <= 1'b0;
      cmd_opcode <= '0;
      cmd_arg    <= '0;
      cmd_ctrl   <= '0;
      cmd_aux    <= '0;
      ok         <= 1'b0;
      fail       <= 1'b0;
      stat_q     <= '0;
    end else begin
      ok   <= 1'b0;
      fail <= 1'b0;
      if (go) begin
        cmd_req    <= 1'b1;
        cmd_opcode <= cmd_in.op;
        cmd_arg    <= cmd_in.arg;
        cmd_ctrl   <= cmd_in.ctrl;
        cmd_aux    <= CTL_AUX;
      end else if (cmd_req && cmd_done) begin
        cmd_req <= 1'b0;
        stat_q  <= rsp_status;
        if (rsp_timeout || rsp_crc_err) fail <= 1'b1;
        else                            ok   <= 1'b1;
      end
    end
  end

  assign card_rdy = stat_q[RDY_BIT];
endmodule

// File: rtl/sd_burst_engine.sv
module sd_burst_engine #(
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 16,
  parameter int WIDE_WORDS   = 32,
  parameter int NARROW_WORDS = 8,
  parameter int BLOCK_WORDS  = 256,
  localparam int WIDE_BPB    = BLOCK_WORDS / WIDE_WORDS,
  localparam int NARROW_BPB  = BLOCK_WORDS / NARROW_WORDS,
  localparam int BURST_W     = CNT_W + $clog2(NARROW_BPB),
  localparam int WORD_W      = $clog2(WIDE_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              wide,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic              go,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_rd,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              burst_end,
  output logic              all_done
);
  logic [BURST_W-1:0] total_q, done_q;
  logic [WORD_W-1:0]  wpb_q, word_q;
  logic               active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q    <= '0;
      done_q     <= '0;
      wpb_q      <= '0;
      word_q     <= '0;
      active_q   <= 1'b0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      burst_end  <= 1'b0;
    end else begin
      fifo_wr   <= 1'b0;
      burst_end <= 1'b0;
      if (load) begin
        total_q <= wide ? BURST_W'(blk_count) * BURST_W'(WIDE_BPB)
                        : BURST_W'(blk_count) * BURST_W'(NARROW_BPB);
        wpb_q   <= wide ? WORD_W'(WIDE_WORDS) : WORD_W'(NARROW_WORDS);
        done_q  <= '0;
      end
      if (go && !active_q) begin
        active_q <= 1'b1;
        word_q   <= '0;
      end else if (active_q) begin
        fifo_wr    <= 1'b1;
        fifo_wdata <= src_data;
        if (word_q == wpb_q - WORD_W'(1)) begin
          active_q  <= 1'b0;
          burst_end <= 1'b1;
          done_q    <= done_q + BURST_W'(1);
        end else begin
          word_q <= word_q + WORD_W'(1);
        end
      end
    end
  end

  assign src_rd   = active_q;
  assign all_done = (done_q == total_q);
endmodule

// File: rtl/sd_blkwr_seq.sv
module sd_blkwr_seq
  import sd_blkwr_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int DATA_W       = 16,
  parameter int STAT_W       = 32,
  parameter int RDY_BIT      = 8,
  parameter int WIDE_WORDS   = 32,
  parameter int NARROW_WORDS = 8,
  parameter int BLOCK_WORDS  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RCA_W-1:0]  rca,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic [ARG_W-1:0]  blk_addr,
  input  logic              wide,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_req,
  output logic [OP_W-1:0]   cmd_opcode,
  output logic [ARG_W-1:0]  cmd_arg,
  output logic [CTRL_W-1:0] cmd_ctrl,
  output logic [CTRL_W-1:0] cmd_aux,
  input  logic              cmd_done,
  input  logic [STAT_W-1:0] rsp_status,
  input  logic              rsp_timeout,
  input  logic              rsp_crc_err,
  input  logic              fifo_empty,
  input  logic              fifo_burst_rdy,
  input  logic              op_done,
  input  logic              bus_stopped,
  output logic              src_rd,
  input  logic [DATA_W-1:0] src_data,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata
);
  state_t state_q, state_d;
  step_t  step_q, step_d;
  logic   issue_d, load_d, go_d, fin_d, fail_d;
  logic   iss_go, eng_load, eng_go;
  cmd_t   iss_cmd;
  logic   wide_q, multi_q;
  logic [RCA_W-1:0] rca_q;
  logic [ARG_W-1:0] addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic   cmd_ok, cmd_fail, card_rdy, burst_end, all_done;
  logic [STAT_W-1:0] stat_q;

  sd_cmd_issuer #(.STAT_W(STAT_W), .RDY_BIT(RDY_BIT)) u_iss (
    .clk(clk), .rst(rst), .go(iss_go), .cmd_in(iss_cmd),
    .cmd_req(cmd_req), .cmd_opcode(cmd_opcode), .cmd_arg(cmd_arg),
    .cmd_ctrl(cmd_ctrl), .cmd_aux(cmd_aux), .cmd_done(cmd_done),
    .rsp_status(rsp_status), .rsp_timeout(rsp_timeout),
    .rsp_crc_err(rsp_crc_err), .ok(cmd_ok), .fail(cmd_fail),
    .stat_q(stat_q), .card_rdy(card_rdy)
  );

  sd_burst_engine #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .WIDE_WORDS(WIDE_WORDS),
    .NARROW_WORDS(NARROW_WORDS), .BLOCK_WORDS(BLOCK_WORDS)
  ) u_eng (
    .clk(clk), .rst(rst), .load(eng_load), .wide(wide_q),
    .blk_count(cnt_q), .go(eng_go), .src_data(src_data), .src_rd(src_rd),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .burst_end(burst_end),
    .all_done(all_done)
  );

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    issue_d = 1'b0;
    load_d  = 1'b0;
    go_d    = 1'b0;
    fin_d   = 1'b0;
    fail_d  = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        issue_d = 1'b1;
        step_d  = STP_STATUS;
        state_d = S_CMD;
      end
      S_CMD: begin
        if (cmd_fail) begin
          fail_d  = 1'b1;
          state_d = S_IDLE;
        end else if (cmd_ok) begin
          case (step_q)
            STP_STATUS: begin
              issue_d = 1'b1;
              step_d  = card_rdy ? STP_BLEN : STP_STATUS;
            end
            STP_BLEN: begin
              issue_d = 1'b1;
              step_d  = wide_q ? STP_APP : STP_WRITE;
            end
            STP_APP: begin
              issue_d = 1'b1;
              step_d  = STP_BUSW;
            end
            STP_BUSW: begin
              issue_d = 1'b1;
              step_d  = STP_WRITE;
            end
            STP_WRITE: begin
              load_d  = 1'b1;
              state_d = S_WAIT_EMPTY;
            end
            default: begin
              fin_d   = 1'b1;
              state_d = S_IDLE;
            end
          endcase
        end
      end
      S_WAIT_EMPTY: if (fifo_empty) state_d = S_WAIT_RDY;
      S_WAIT_RDY: if (fifo_burst_rdy) begin
        go_d    = 1'b1;
        state_d = S_BURST;
      end
      S_BURST: if (burst_end) state_d = all_done ? S_WAIT_OP : S_WAIT_RDY;
      S_WAIT_OP: if (op_done) state_d = S_WAIT_BUS;
      S_WAIT_BUS: if (bus_stopped) begin
        if (multi_q) begin
          issue_d = 1'b1;
          step_d  = STP_STOP;
          state_d = S_CMD;
        end else begin
          fin_d   = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      step_q   <= STP_STATUS;
      iss_go   <= 1'b0;
      iss_cmd  <= '0;
      eng_load <= 1'b0;
      eng_go   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      wide_q   <= 1'b0;
      multi_q  <= 1'b0;
      rca_q    <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      iss_go   <= issue_d;
      eng_load <= load_d;
      eng_go   <= go_d;
      if (issue_d)
        iss_cmd <= cmd_of(step_d, (state_q == S_IDLE) ? rca : rca_q,
                          addr_q, multi_q);
      if (state_q == S_IDLE && start) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        err     <= 1'b0;
        wide_q  <= wide;
        multi_q <= (blk_count > CNT_W'(1));
        rca_q   <= rca;
        addr_q  <= blk_addr;
        cnt_q   <= blk_count;
      end
      if (fin_d) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      if (fail_d) begin
        busy <= 1'b0;
        err  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sd_blkwr_seq_chk.sv
module sd_blkwr_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] blk_count,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             cmd_req,
  input logic             cmd_done,
  input logic [5:0]       cmd_opcode,
  input logic [31:0]      cmd_arg,
  input logic [7:0]       cmd_ctrl,
  input logic [7:0]       cmd_aux,
  input logic             fifo_wr,
  input logic             src_rd
);
  logic multi_seen;

  always_ff @(posedge clk) begin
    if (rst)                 multi_seen <= 1'b0;
    else if (start && !busy) multi_seen <= (blk_count > CNT_W'(1));
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_req && !cmd_done |=> cmd_req && $stable(cmd_opcode) && $stable(cmd_arg) && $stable(cmd_ctrl)); // R6
  AST_AUX_FIXED: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> cmd_aux == 8'h40); // R6
  AST_WRITE_CTRL: assert property (@(posedge clk) disable iff (rst)
    cmd_req && (cmd_opcode == 6'd24 || cmd_opcode == 6'd25) |-> cmd_ctrl == 8'h19); // R5
  AST_STOP_MULTI: assert property (@(posedge clk) disable iff (rst)
    cmd_req && cmd_opcode == 6'd12 |-> multi_seen); // R9
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> busy); // R8
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(src_rd)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_req); // R11
endmodule

bind sd_blkwr_seq sd_blkwr_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .blk_count(blk_count), .busy(busy),
  .done(done), .err(err), .cmd_req(cmd_req), .cmd_done(cmd_done),
  .cmd_opcode(cmd_opcode), .cmd_arg(cmd_arg), .cmd_ctrl(cmd_ctrl),
  .cmd_aux(cmd_aux), .fifo_wr(fifo_wr), .src_rd(src_rd)
);

// File: tb/sim_sd_blkwr_seq.sv
`timescale 1ns/1ps
module sim_sd_blkwr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] rca = 16'h4A21;
  logic [15:0] blk_count = 16'd1;
  logic [31:0] blk_addr = '0;
  logic        wide = 1'b0;
  logic        busy, done, err, cmd_req, src_rd, fifo_wr;
  logic [5:0]  cmd_opcode;
  logic [31:0] cmd_arg;
  logic [7:0]  cmd_ctrl, cmd_aux;
  logic        cmd_done = 1'b0;
  logic [31:0] rsp_status = '0;
  logic        rsp_timeout = 1'b0, rsp_crc_err = 1'b0;
  logic        fifo_empty = 1'b0, fifo_burst_rdy = 1'b1;
  logic        op_done = 1'b0, bus_stopped = 1'b0;
  logic [15:0] src_ctr = '0;
  logic [15:0] src_data;
  logic [15:0] fifo_wdata;

  int checks = 0, fails = 0;
  logic [45:0] exp_q[$];
  int  nrdy = 0, inj_op = -1, inj_kind = 0, empty_cnt = 0;
  int  words = 0, inb = 0, gap = 0, post = 0, bsize = 8, total_exp = 0;
  logic [15:0] exp_word = '0;
  bit  arm = 0, cut = 0;

  always #2.5 clk = ~clk;
  assign src_data = src_ctr;
  always @(posedge clk) if (src_rd) src_ctr <= src_ctr + 16'd1;

  sd_blkwr_seq u0 (
    .clk(clk), .rst(rst), .start(start), .rca(rca), .blk_count(blk_count),
    .blk_addr(blk_addr), .wide(wide), .busy(busy), .done(done), .err(err),
    .cmd_req(cmd_req), .cmd_opcode(cmd_opcode), .cmd_arg(cmd_arg),
    .cmd_ctrl(cmd_ctrl), .cmd_aux(cmd_aux), .cmd_done(cmd_done),
    .rsp_status(rsp_status), .rsp_timeout(rsp_timeout),
    .rsp_crc_err(rsp_crc_err), .fifo_empty(fifo_empty),
    .fifo_burst_rdy(fifo_burst_rdy), .op_done(op_done),
    .bus_stopped(bus_stopped), .src_rd(src_rd), .src_data(src_data),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [5:0] op);
    case (op)
      6'd13: return "R2";
      6'd16: return "R3";
      6'd55, 6'd6: return "R4";
      6'd24, 6'd25: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic push(input logic [5:0] op, input logic [31:0] arg, input logic [7:0] ctl);
    if (!cut) begin
      exp_q.push_back({op, arg, ctl});
      if (int'(op) == inj_op) cut = 1;
    end
  endtask

  // responder: scoreboard monitor for the command port
  initial begin
    bit seen = 0;
    int hold = 0;
    logic [45:0] cur = '0, e;
    forever begin
      @(negedge clk);
      cmd_done = 0; rsp_timeout = 0; rsp_crc_err = 0;
      if (empty_cnt > 0) begin
        empty_cnt--;
        if (empty_cnt == 0) fifo_empty = 1;
      end
      if (!cmd_req) seen = 0;
      else if (!seen) begin
        seen = 1; hold = 2;
        cur = {cmd_opcode, cmd_arg, cmd_ctrl};
        if (exp_q.size() == 0)
          chk(0, "R11", "unexpected command", 64'(cur), 64'h0);
        else begin
          e = exp_q.pop_front();
          chk(cur == e, req_of(e[45:40]), "command fields", 64'(cur), 64'(e));
        end
        chk(cmd_aux == 8'h40, "R6", "aux byte", 64'(cmd_aux), 64'h40);
        if (cmd_opcode == 6'd12)
          chk(bus_stopped, "R9", "stop before bus idle", 64'(bus_stopped), 64'h1);
      end else if (hold > 0) begin
        chk({cmd_opcode, cmd_arg, cmd_ctrl} == cur, "R6", "held fields",
            64'({cmd_opcode, cmd_arg, cmd_ctrl}), 64'(cur));
        hold--;
      end else begin
        cmd_done = 1;
        rsp_status = '0;
        if (cmd_opcode == 6'd13) begin
          if (nrdy > 0) nrdy--;
          else rsp_status = 32'h0000_0100;
        end
        if (int'(cmd_opcode) == inj_op) begin
          if (inj_kind == 0) rsp_timeout = 1; else rsp_crc_err = 1;
          inj_op = -1;
        end
        if (cmd_opcode == 6'd24 || cmd_opcode == 6'd25) empty_cnt = 6;
      end
    end
  end

  // data monitor and FIFO / data-line model
  initial begin
    forever begin
      @(negedge clk);
      if (fifo_wr) begin
        chk(fifo_wdata == exp_word, "R8", "word order", 64'(fifo_wdata), 64'(exp_word));
        if (!fifo_empty) chk(0, "R7", "write before FIFO empty", 64'h1, 64'h0);
        if (!fifo_burst_rdy) chk(0, "R8", "write without burst grant", 64'(inb), 64'(bsize));
        exp_word++; words++; inb++;
        if (inb == bsize) begin inb = 0; fifo_burst_rdy = 0; gap = 4; end
      end else if (gap > 0) begin
        gap--;
        if (gap == 0 && words < total_exp) fifo_burst_rdy = 1;
      end
      if (total_exp > 0 && words == total_exp) begin
        post++;
        if (post == 4) op_done = 1;
        if (post == 8) bus_stopped = 1;
      end
      if (arm && done && !bus_stopped)
        chk(0, "R9", "finished before bus idle", 64'h1, 64'h0);
    end
  end

  task automatic run(input int cnt, input logic [31:0] addr, input bit w,
                     input int nr, input int iop, input int ikind, input bit poke);
    int t, exp_words, base;
    @(negedge clk);
    arm = 0; cut = 0; inj_op = iop; inj_kind = ikind; nrdy = nr;
    fifo_empty = 0; fifo_burst_rdy = 1; op_done = 0; bus_stopped = 0;
    words = 0; inb = 0; post = 0; gap = 0; bsize = w ? 32 : 8;
    base = fails;
    for (int i = 0; i <= nr; i++) push(6'd13, {rca, 16'h0}, 8'h01);
    push(6'd16, 32'h200, 8'h01);
    if (w) begin
      push(6'd55, {rca, 16'h0}, 8'h01);
      push(6'd6, 32'h2, 8'h01);
    end
    push((cnt == 1) ? 6'd24 : 6'd25, addr, 8'h19);
    if (cnt > 1) push(6'd12, 32'h0, 8'h41);
    exp_words = cut ? 0 : cnt * 256;
    total_exp = exp_words;
    blk_count = 16'(cnt); blk_addr = addr; wide = w; start = 1;
    @(negedge clk);
    start = 0; arm = 1;
    t = 0;
    while (!(done || err) && t < 30000) begin
      @(negedge clk);
      t++;
      if (poke && t == 40) begin
        start = 1; blk_count = 16'(cnt + 5); wide = !w; blk_addr = ~addr;
      end else start = 0;
    end
    if (t >= 30000) chk(0, "R10", "watchdog: run never ended", 64'(t), 64'h0);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, cut ? "R11" : "R9", "commands left unissued", 64'(exp_q.size()), 64'h0);
    exp_q.delete();
    chk(words == exp_words, "R8", "total words", 64'(words), 64'(exp_words));
    chk(busy == 0, "R10", "busy after end", 64'(busy), 64'h0);
    if (!cut) chk(done == 1 && err == 0, "R10", "done/err", 64'({done, err}), 64'h2);
    else      chk(err == 1 && done == 0, "R11", "done/err", 64'({done, err}), 64'h1);
    if (poke) chk(fails == base, "R12", "start while busy disturbed run", 64'(fails - base), 64'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({busy, done, err, cmd_req, fifo_wr, src_rd} == 6'b0, "R1", "reset outputs",
        64'({busy, done, err, cmd_req, fifo_wr, src_rd}), 64'h0);
    run(1, 32'h0000_1000, 1'b0, 2, -1, 0, 1'b0);   // R2 polling, R5 single, R8 narrow
    run(3, 32'h0002_0000, 1'b1, 0, -1, 0, 1'b0);   // R4 wide, R5 multi, R9 stop
    run(2, 32'h0000_0040, 1'b0, 1, -1, 0, 1'b1);   // R12 start while busy
    run(2, 32'h0000_0080, 1'b1, 0, 55, 0, 1'b0);   // R11 timeout on app command
    run(1, 32'h0000_0100, 1'b1, 0, 13, 1, 1'b0);   // R11 crc error on first poll
    run(1, 32'h0000_0200, 1'b1, 1, -1, 0, 1'b0);   // R11 err cleared by new start, R3
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL R10 global watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule